// File: doc/BRIEF.md
# Micro-op Condition Code Evaluator

A combinational decision block. It decides whether a conditional micro-operation is allowed to commit. It takes a flag word and a 5-bit condition selector and returns one bit, `take_o`. The flag word holds the architectural flags (carry, parity, zero, sign, overflow) and two extra flags that the micro-code keeps for itself: an extra carry and an extra zero.

The selector space has two halves. Codes 0 to 15 are positive tests. Codes 16 to 31 mostly negate the test at the same low four bits. The supported tests are:

- constants (always and never);
- single-flag tests;
- unsigned below-or-equal, signed less, and signed less-or-equal;
- two tests that end a repeated string loop, each mixing the extra zero flag with the zero flag.

Three string-related codes in each half are reserved. On a reserved code the block drives `take_o` low and raises `rsv_err_o` for as long as that code is present.

Top module: `ucond_eval`

## Requirements
- R1: Selector 0 gives `take_o`=1 and selector 16 gives `take_o`=0, whatever the flags are.
- R2: Selector 1 returns the extra carry flag (flag bit 3), and selector 17 returns its inverse. Selector 2 returns the extra zero flag (flag bit 5), and selector 18 returns its inverse.
- R3: The single-flag tests are:
  - overflow (bit 11): selector 8, inverse 24;
  - carry (bit 0): selector 9, inverse 25;
  - zero (bit 6): selector 10, inverse 26;
  - sign (bit 7): selector 12, inverse 28;
  - parity (bit 2): selector 13, inverse 29.
- R4: Selector 11 returns carry OR zero, and selector 27 returns NOT(carry OR zero).
- R5: Selector 14 returns sign XOR overflow, and selector 30 returns its inverse. Selector 15 returns (sign XOR overflow) OR zero, and selector 31 returns its inverse.
- R6: Selector 3 returns NOT((NOT extra zero) AND zero), and selector 19 returns (NOT extra zero) AND zero.
- R7: Selector 7 returns (NOT extra zero) AND zero. Selector 23 returns (NOT extra zero) AND (NOT zero), which is not the inverse of selector 7. Neither test can pass while extra zero is set.
- R8: Selectors 4, 5, 6, 20, 21 and 22 are reserved: they give `take_o`=0 and `rsv_err_o`=1. Every other selector gives `rsv_err_o`=0.
- R9: Flag bits other than 0, 2, 3, 5, 6, 7 and 11 have no effect on either output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| flags_i | input | FLAG_W (16) | Flag word; bit positions as in R2 and R3 |
| sel_i | input | 5 | Condition selector |
| take_o | output | 1 | Condition result |
| rsv_err_o | output | 1 | High while a reserved selector is applied |

## Verification
Each test is driven with flag words in which only the bits it reads are set or cleared. This shows that each selector decodes to the right flag and polarity.

The compound tests get pairs of words that differ in one operand: sign against overflow, and zero alone. These pairs separate OR from XOR, and a correct inverse from a wrong one.

The string tests are tried with every combination of extra zero and zero. This shows that selector 23 is not the plain inverse of selector 7.

A sweep of all 32 selectors checks the error output. It also compares each result under an all-zero word against a word in which only the unused bits are set.

// File: rtl/ucond_eval.sv
module ucond_eval #(
  parameter int FLAG_W  = 16,
  parameter int CF_POS  = 0,
  parameter int PF_POS  = 2,
  parameter int ECF_POS = 3,
  parameter int EZF_POS = 5,
  parameter int ZF_POS  = 6,
  parameter int SF_POS  = 7,
  parameter int OF_POS  = 11
) (
  input  logic [FLAG_W-1:0] flags_i,
  input  logic [4:0]        sel_i,
  output logic              take_o,
  output logic              rsv_err_o
);

  logic cf, pf, ecf, ezf, zf, sf, of;
  logic base, rsv, str_nz;
  logic unused_flags;

  assign cf  = flags_i[CF_POS];
  assign pf  = flags_i[PF_POS];
  assign ecf = flags_i[ECF_POS];
  assign ezf = flags_i[EZF_POS];
  assign zf  = flags_i[ZF_POS];
  assign sf  = flags_i[SF_POS];
  assign of  = flags_i[OF_POS];
  assign unused_flags = ^flags_i;

  always_comb begin
    base = 1'b0;
    case (sel_i[3:0])
      4'd0:  base = 1'b1;
      4'd1:  base = ecf;
      4'd2:  base = ezf;
      4'd3:  base = ~(~ezf & zf);
      4'd7:  base = ~ezf & zf;
      4'd8:  base = of;
      4'd9:  base = cf;
      4'd10: base = zf;
      4'd11: base = cf | zf;
      4'd12: base = sf;
      4'd13: base = pf;
      4'd14: base = sf ^ of;
      4'd15: base = (sf ^ of) | zf;
      default: base = 1'b0;
    endcase
  end

  assign rsv    = (sel_i[3:0] == 4'd4) || (sel_i[3:0] == 4'd5) || (sel_i[3:0] == 4'd6);
  assign str_nz = ~ezf & ~zf;

  assign rsv_err_o = rsv;
  assign take_o    = rsv ? 1'b0 :
                     (sel_i == 5'd23) ? str_nz :
                     (base ^ sel_i[4]);

endmodule

// File: rtl/ucond_eval_chk.sv
module ucond_eval_chk #(
  parameter int FLAG_W  = 16,
  parameter int EZF_POS = 5,
  parameter int ZF_POS  = 6
) (
  input logic [FLAG_W-1:0] flags_i,
  input logic [4:0]        sel_i,
  input logic              take_o,
  input logic              rsv_err_o
);
  logic unused_chk;
  assign unused_chk = ^flags_i;

  always_comb begin
    if (rsv_err_o) AST_RSV_FORCES_LOW: assert (!take_o) else $error("reserved code passed"); // R8
    if (sel_i[3]) AST_CMP_NO_ERR: assert (!rsv_err_o) else $error("error on valid code"); // R8
    if (sel_i == 5'd0) AST_ALWAYS_TAKEN: assert (take_o) else $error("always failed"); // R1
    if (sel_i == 5'd16) AST_NEVER_TAKEN: assert (!take_o) else $error("never passed"); // R1
    if ((sel_i == 5'd7 || sel_i == 5'd23) && flags_i[EZF_POS])
      AST_STR_EZF_BLOCKS: assert (!take_o) else $error("string test with extra zero"); // R7
    if (sel_i == 5'd11 && flags_i[ZF_POS])
      AST_BE_ON_ZERO: assert (take_o) else $error("below-or-equal missed zero"); // R4
  end
endmodule

bind ucond_eval ucond_eval_chk #(.FLAG_W(FLAG_W), .EZF_POS(EZF_POS), .ZF_POS(ZF_POS)) u_chk (
  .flags_i(flags_i), .sel_i(sel_i), .take_o(take_o), .rsv_err_o(rsv_err_o)
);

// File: tb/sim_ucond_eval.sv
module sim_ucond_eval;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] flags;
  logic [4:0]  sel;
  logic        take, err;
  int checks = 0, errors = 0;

  ucond_eval u0 (.flags_i(flags), .sel_i(sel), .take_o(take), .rsv_err_o(err));

  // {req[3:0], sel[4:0], flags[15:0], take, err}
  localparam int NV = 38;
  localparam logic [26:0] VEC [NV] = '{
    {4'd1, 5'd0,  16'h0000, 1'b1, 1'b0}, // R1
    {4'd1, 5'd16, 16'hFFFF, 1'b0, 1'b0}, // R1
    {4'd2, 5'd1,  16'h0008, 1'b1, 1'b0}, // R2
    {4'd2, 5'd1,  16'hFFF7, 1'b0, 1'b0}, // R2
    {4'd2, 5'd17, 16'h0000, 1'b1, 1'b0}, // R2
    {4'd2, 5'd2,  16'h0020, 1'b1, 1'b0}, // R2
    {4'd2, 5'd18, 16'h0020, 1'b0, 1'b0}, // R2
    {4'd3, 5'd8,  16'h0800, 1'b1, 1'b0}, // R3
    {4'd3, 5'd24, 16'h0800, 1'b0, 1'b0}, // R3
    {4'd3, 5'd9,  16'h0001, 1'b1, 1'b0}, // R3
    {4'd3, 5'd10, 16'h0040, 1'b1, 1'b0}, // R3
    {4'd3, 5'd26, 16'h0000, 1'b1, 1'b0}, // R3
    {4'd3, 5'd12, 16'h0080, 1'b1, 1'b0}, // R3
    {4'd3, 5'd13, 16'h0004, 1'b1, 1'b0}, // R3
    {4'd3, 5'd29, 16'h0004, 1'b0, 1'b0}, // R3
    {4'd4, 5'd11, 16'h0000, 1'b0, 1'b0}, // R4
    {4'd4, 5'd11, 16'h0040, 1'b1, 1'b0}, // R4
    {4'd4, 5'd27, 16'h0001, 1'b0, 1'b0}, // R4
    {4'd4, 5'd27, 16'h0000, 1'b1, 1'b0}, // R4
    {4'd5, 5'd14, 16'h0880, 1'b0, 1'b0}, // R5
    {4'd5, 5'd14, 16'h0080, 1'b1, 1'b0}, // R5
    {4'd5, 5'd30, 16'h0800, 1'b0, 1'b0}, // R5
    {4'd5, 5'd15, 16'h0840, 1'b1, 1'b0}, // R5
    {4'd5, 5'd15, 16'h0880, 1'b0, 1'b0}, // R5
    {4'd5, 5'd31, 16'h0000, 1'b1, 1'b0}, // R5
    {4'd6, 5'd3,  16'h0040, 1'b0, 1'b0}, // R6
    {4'd6, 5'd3,  16'h0060, 1'b1, 1'b0}, // R6
    {4'd6, 5'd19, 16'h0040, 1'b1, 1'b0}, // R6
    {4'd6, 5'd19, 16'h0000, 1'b0, 1'b0}, // R6
    {4'd7, 5'd7,  16'h0040, 1'b1, 1'b0}, // R7
    {4'd7, 5'd7,  16'h0060, 1'b0, 1'b0}, // R7
    {4'd7, 5'd23, 16'h0000, 1'b1, 1'b0}, // R7
    {4'd7, 5'd23, 16'h0020, 1'b0, 1'b0}, // R7
    {4'd7, 5'd23, 16'h0040, 1'b0, 1'b0}, // R7
    {4'd8, 5'd4,  16'hFFFF, 1'b0, 1'b1}, // R8
    {4'd8, 5'd22, 16'h0000, 1'b0, 1'b1}, // R8
    {4'd9, 5'd9,  16'hFFFE, 1'b0, 1'b0}, // R9
    {4'd9, 5'd12, 16'hFF7F, 1'b0, 1'b0}  // R9
  };

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic t0;
    logic [15:0] ign;
    ign = 16'hF712;
    flags = '0; sel = '0;
    @(negedge clk);
    chk("R1", "initial take", take, 1'b1);
    chk("R8", "initial err", err, 1'b0);

    for (int i = 0; i < NV; i++) begin
      @(posedge clk);
      sel = VEC[i][22:18]; flags = VEC[i][17:2];
      @(negedge clk);
      chk($sformatf("R%0d", VEC[i][26:23]), $sformatf("vec %0d take", i), take, VEC[i][1]);
      chk($sformatf("R%0d", VEC[i][26:23]), $sformatf("vec %0d err", i), err, VEC[i][0]);
    end

    for (int s = 0; s < 32; s++) begin
      @(posedge clk);
      sel = 5'(s); flags = 16'h0000;
      @(negedge clk);
      t0 = take;
      // R8: reserved set is low nibble 4..6
      chk("R8", $sformatf("sweep err sel %0d", s), err, ((s % 16) >= 4 && (s % 16) <= 6));
      @(posedge clk);
      flags = ign;
      @(negedge clk);
      chk("R9", $sformatf("ignored bits sel %0d", s), take, t0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule